// File: doc/BRIEF.md
# Multi-format serial audio receiver

This receiver takes PCM audio from up to four serial data lines. A bit clock and a frame clock time the lines. It delivers 24-bit two's complement samples for eight channels. The design logic runs directly on the bit clock. Every line is sampled on the rising edge, and the most significant bit arrives first. A 4-bit format code selects one of two kinds of framing:

- **Level-framed formats.** Each data line carries one channel pair. The level of the frame clock selects the left or the right half of the frame.
- **Pulse-framed TDM.** Line 0 alone carries all eight channels in 32-bit slots. Only the rising edge of the frame pulse is used for alignment.

Completed samples leave on a single sample bus. Each sample comes with its channel index and a one-cycle valid strobe. A level-framed half-frame produces a burst of four samples. A TDM frame produces a burst of eight samples, and only after the frame has been confirmed to be exactly 256 bit clocks long. Any other TDM frame length raises a one-cycle error pulse, and that frame's samples are dropped.

Top module: `serial_audio_rx`

## Requirements
- R1: While reset is low, and on the first cycle after it, `smp_valid`, `frame_err`, `smp_chan` and `smp_data` are all zero.
- R2: Format code 0 (left-justified) works as follows:
  - The bit sampled on the first rising edge that sees a new frame-clock level is bit 23 (MSB) of the sample.
  - The next 23 edges carry the remaining bits in descending order.
  - A high frame clock marks the left channel.
- R3: Format code 1 (I2S) has the MSB one rising edge later than code 0, and a low frame clock marks the left channel.
- R4: Format codes 2, 4 and 5 (right-justified) behave as follows:
  - They carry 16, 20 and 18 bits respectively.
  - The last bit sampled before the frame-clock level changes is the LSB.
  - The value is sign-extended to 24 bits and emitted after that change.
  - A high frame clock marks the left channel.
- R5: In the level-framed formats:
  - Line k carries channel 2k (left) and channel 2k+1 (right).
  - Each completed half-frame yields four consecutive valid cycles.
  - Those four cycles carry channels in ascending order, all from the same side.
- R6: Format code 3 (TDM) behaves as follows:
  - Only line 0 is used.
  - The MSB of channel 0 is sampled on the second rising edge after the frame clock rises.
  - Channel s occupies a 32-bit slot starting 32*s edges later, and its first 24 bits are the sample.
- R7: In TDM, only the rising edge of the frame clock aligns the frame. A high pulse lasting 1 to 255 bit clocks gives the same samples.
- R8: In TDM, the frame length decides what is emitted:
  - A frame of exactly 256 bit clocks is emitted as eight valid cycles, channels 0 to 7 in order, after the next frame-clock rise.
  - A frame of any other length produces a one-cycle `frame_err` pulse instead, and none of its samples.
- R9: Format codes 6 to 15 produce no valid samples and no framing error.
- R10: Nothing is emitted before the first frame-clock edge after reset has been seen, even if the frame clock is held at a constant level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk | input | 1 | Bit clock; data and frame clock sampled on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| lrck | input | 1 | Frame clock (level-framed half select, or TDM frame pulse) |
| sdata | input | 4 | Serial data lines, one per channel pair |
| fmt | input | 4 | Framing format code |
| smp_valid | output | 1 | One-cycle strobe per delivered sample |
| smp_chan | output | 3 | Channel index of the delivered sample |
| smp_data | output | 24 | Sign-extended two's complement sample |
| frame_err | output | 1 | One-cycle pulse for a TDM frame with the wrong length |

## Verification
Several properties are checked on every cycle:

- the framing error is a single-cycle pulse, is raised only under the TDM code, and never precedes alignment;
- no sample appears before the first alignment edge;
- the frame-length counter saturates instead of wrapping;
- an output burst never exceeds eight samples.

Only the bench scenarios can show the bit-exact sample values. These include how each format positions its bits, right-justified sign extension, channel numbering per line and side, and indifference to the TDM pulse width. The scenarios also show that a mis-sized TDM frame is dropped while the frames around it still come out.

// File: rtl/serial_audio_rx.sv
module serial_audio_rx #(
  parameter int DW    = 24,
  parameter int SLOT  = 32,
  parameter int LINES = 4,
  localparam int NCH  = 2 * LINES,
  localparam int CHW  = $clog2(NCH)
) (
  input  logic             bclk,
  input  logic             rst_n,
  input  logic             lrck,
  input  logic [LINES-1:0] sdata,
  input  logic [3:0]       fmt,
  output logic             smp_valid,
  output logic [CHW-1:0]   smp_chan,
  output logic [DW-1:0]    smp_data,
  output logic             frame_err
);

  localparam int FRAME = NCH * SLOT;
  localparam int CW    = $clog2(FRAME) + 1;
  localparam logic [3:0] F_LJ = 4'd0, F_I2S = 4'd1, F_RJ16 = 4'd2,
                         F_TDM = 4'd3, F_RJ20 = 4'd4, F_RJ18 = 4'd5;

  logic          lr_q, primed, synced;
  logic [CW-1:0] cnt, pos;
  logic [DW-2:0] shreg [LINES];
  logic [DW-1:0] word  [LINES];
  logic [DW-1:0] hold  [NCH];
  logic [CHW:0]  em_left;
  logic [CHW-1:0] em_ch;
  logic          em_two;
  int            rjn;

  function automatic logic [DW-1:0] sext(input logic [DW-1:0] x, input int n);
    logic signed [DW-1:0] t;
    t = x << (DW - n);
    return t >>> (DW - n);
  endfunction

  always_comb begin
    case (fmt)
      F_RJ16:  rjn = 16;
      F_RJ20:  rjn = 20;
      F_RJ18:  rjn = 18;
      default: rjn = 0;
    endcase
    for (int k = 0; k < LINES; k++) word[k] = {shreg[k], sdata[k]};
  end

  wire tdm      = (fmt == F_TDM);
  wire mark     = primed & (tdm ? (lrck & ~lr_q) : (lrck ^ lr_q));
  wire live     = mark | synced;
  assign pos    = mark ? '0 : cnt;

  wire mid_done = live & (((fmt == F_LJ) && (pos == CW'(DW - 1))) ||
                          ((fmt == F_I2S) && (pos == CW'(DW))));
  wire rj_done  = mark & synced & (rjn != 0);
  wire side     = rj_done ? ~lr_q : ((fmt == F_I2S) ? lrck : ~lrck);
  wire tdm_slot = live & tdm & ((pos % CW'(SLOT)) == CW'(DW)) & (pos < CW'(FRAME));
  wire tdm_good = mark & tdm & synced & (cnt == CW'(FRAME));
  wire tdm_bad  = mark & tdm & synced & (cnt != CW'(FRAME));
  wire [CHW-1:0] slot = CHW'(pos / CW'(SLOT));

  always_ff @(posedge bclk) begin
    if (!rst_n) begin
      lr_q      <= 1'b0;
      primed    <= 1'b0;
      synced    <= 1'b0;
      cnt       <= '0;
      em_left   <= '0;
      em_ch     <= '0;
      em_two    <= 1'b0;
      smp_valid <= 1'b0;
      smp_chan  <= '0;
      smp_data  <= '0;
      frame_err <= 1'b0;
      for (int k = 0; k < LINES; k++) shreg[k] <= '0;
      for (int c = 0; c < NCH; c++) hold[c] <= '0;
    end else begin
      primed    <= 1'b1;
      lr_q      <= lrck;
      if (mark) synced <= 1'b1;
      cnt       <= mark ? CW'(1) : ((&cnt) ? cnt : cnt + CW'(1));
      for (int k = 0; k < LINES; k++) shreg[k] <= word[k][DW-2:0];
      frame_err <= tdm_bad;

      if (em_left != '0) begin
        smp_valid <= 1'b1;
        smp_chan  <= em_ch;
        smp_data  <= hold[em_ch];
        em_ch     <= em_ch + (em_two ? CHW'(2) : CHW'(1));
        em_left   <= em_left - 1'b1;
      end else begin
        smp_valid <= 1'b0;
      end

      if (mid_done || rj_done) begin
        for (int k = 0; k < LINES; k++)
          hold[CHW'(2 * k) + CHW'(side)] <= mid_done ? word[k] : sext({1'b0, shreg[k]}, rjn);
        em_left <= (CHW + 1)'(LINES);
        em_ch   <= CHW'(side);
        em_two  <= 1'b1;
      end else if (tdm_slot) begin
        hold[slot] <= word[0];
      end

      if (tdm_good) begin
        em_left <= (CHW + 1)'(NCH);
        em_ch   <= '0;
        em_two  <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/serial_audio_rx_chk.sv
module serial_audio_rx_chk #(
  parameter int CW  = 9,
  parameter int CHW = 3,
  parameter int NCH = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic [3:0]    fmt,
  input logic          smp_valid,
  input logic          frame_err,
  input logic          synced,
  input logic          mark,
  input logic [CW-1:0] cnt,
  input logic [CHW:0]  em_left
);

  assert_err_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |=> !frame_err);

  assert_err_tdm_only_R8: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |-> $past(fmt) == 4'd3);

  assert_no_early_out_R10: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid |-> synced);

  assert_err_after_lock_R10: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |-> synced);

  assert_cnt_saturates_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cnt) == {CW{1'b1}} && !$past(mark)) |-> cnt == {CW{1'b1}});

  assert_burst_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    em_left <= (CHW + 1)'(NCH));

endmodule

bind serial_audio_rx serial_audio_rx_chk #(.CW(CW), .CHW(CHW), .NCH(NCH)) u_chk (
  .clk(bclk), .rst_n(rst_n), .fmt(fmt), .smp_valid(smp_valid),
  .frame_err(frame_err), .synced(synced), .mark(mark), .cnt(cnt),
  .em_left(em_left)
);

// File: tb/serial_audio_rx_test.sv
module serial_audio_rx_test;
  localparam int CLK_PERIOD = 10;

  logic        bclk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lrck = 1'b0;
  logic [3:0]  sdata = '0;
  logic [3:0]  fmt = '0;
  logic        smp_valid, frame_err;
  logic [2:0]  smp_chan;
  logic [23:0] smp_data;

  int checks = 0, errors = 0, err_seen = 0;
  bit done = 0;
  logic [26:0] got[$];
  logic [26:0] expq[$];

  serial_audio_rx uut (.bclk(bclk), .rst_n(rst_n), .lrck(lrck), .sdata(sdata),
    .fmt(fmt), .smp_valid(smp_valid), .smp_chan(smp_chan), .smp_data(smp_data),
    .frame_err(frame_err));

  always #(CLK_PERIOD/2) bclk = ~bclk;

  always @(negedge bclk) begin
    if (rst_n && smp_valid) got.push_back({smp_chan, smp_data});
    if (rst_n && frame_err) err_seen++;
  end

  task automatic check(input bit ok, input string req, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, expv);
    end
  endtask

  function automatic logic [23:0] gen(input int seed);
    if (seed % 5 == 0) return 24'h800000;
    if (seed % 7 == 0) return 24'h7FFFFF;
    return 24'(seed * 32'h9E3779B1 ^ (seed << 7));
  endfunction

  task automatic do_reset();
    @(negedge bclk);
    rst_n = 1'b0; lrck = 1'b0; sdata = '0;
    repeat (3) @(negedge bclk);
    rst_n = 1'b1;
    got.delete(); expq.delete(); err_seen = 0;
  endtask

  task automatic compare(input string req, input int exp_err);
    repeat (12) @(negedge bclk);
    check(got.size() == expq.size(), req, got.size(), expq.size());
    for (int i = 0; i < got.size() && i < expq.size(); i++)
      check(got[i] == expq[i], req, got[i], expq[i]);
    check(err_seen == exp_err, {req, " frame_err count"}, err_seen, exp_err);
  endtask

  task automatic drive(input logic lr, input logic [3:0] d);
    @(negedge bclk);
    lrck = lr; sdata = d;
  endtask

  task automatic run_pcm(input logic [3:0] f, input int halves, input int base, input string req);
    int n;
    do_reset();
    fmt = f;
    n = (f == 2) ? 16 : (f == 4) ? 20 : (f == 5) ? 18 : 0;
    repeat (4) drive(1'b0, 4'h0);
    for (int h = 0; h < halves; h++) begin
      logic lr;
      logic [23:0] w[4];
      lr = (h % 2 == 0);
      for (int k = 0; k < 4; k++) begin
        int m, sd;
        w[k] = gen(base + h * 4 + k);
        sd = (f == 1) ? int'(lr) : int'(!lr);
        if (n != 0) begin
          m = int'(w[k]) % (1 << n);
          if (m >= (1 << (n - 1))) m -= (1 << n);
          w[k] = 24'(m);
        end
        if (f <= 2 || f == 4 || f == 5) expq.push_back({3'(2 * k + sd), w[k]});
      end
      for (int p = 0; p < 32; p++) begin
        logic [3:0] d;
        for (int k = 0; k < 4; k++) begin
          if (f == 1) d[k] = (p >= 1 && p <= 24) ? w[k][24 - p] : 1'b0;
          else if (n != 0) d[k] = (p >= 32 - n) ? w[k][31 - p] : 1'b0;
          else d[k] = (p < 24) ? w[k][23 - p] : 1'b0;
        end
        drive(lr, d);
      end
    end
    repeat (4) drive(halves % 2 == 1 ? 1'b0 : 1'b1, 4'h0);
    compare(req, 0);
  endtask

  task automatic run_tdm(input int lens[5], input int pws[5], input int base, input string req);
    int nerr = 0;
    do_reset();
    fmt = 4'd3;
    repeat (4) drive(1'b0, 4'h0);
    for (int f = 0; f < 5; f++) begin
      logic [23:0] w[8];
      for (int s = 0; s < 8; s++) w[s] = gen(base + f * 8 + s);
      if (lens[f] == 256) for (int s = 0; s < 8; s++) expq.push_back({3'(s), w[s]});
      else nerr++;
      for (int p = 0; p < lens[f]; p++) begin
        logic b;
        int q;
        b = 1'b0;
        if (p >= 1) begin
          q = p - 1;
          if (q / 32 < 8 && q % 32 < 24) b = w[q / 32][23 - q % 32];
        end
        drive(p < pws[f], {3'(p & 7), b});
      end
    end
    drive(1'b1, 4'h0);
    repeat (3) drive(1'b0, 4'h0);
    compare(req, nerr);
  endtask

  initial begin
    repeat (200000) @(posedge bclk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge bclk);
    check(smp_valid == 0, "R1 valid in reset", smp_valid, 0);
    check(frame_err == 0, "R1 err in reset", frame_err, 0);
    check(smp_chan == 0 && smp_data == 0, "R1 bus in reset", {smp_chan, smp_data}, 0);
    rst_n = 1'b1;
    @(negedge bclk);
    check(smp_valid == 0 && frame_err == 0, "R1 after reset", {smp_valid, frame_err}, 0);

    do_reset();
    fmt = 4'd0;
    lrck = 1'b1;
    repeat (60) drive(1'b1, 4'hF);
    compare("R10 no alignment edge", 0);

    run_pcm(4'd0, 6, 11, "R2 R5 left-justified");
    run_pcm(4'd1, 6, 50, "R3 R5 I2S");
    run_pcm(4'd2, 4, 90, "R4 right-justified 16");
    run_pcm(4'd4, 4, 130, "R4 right-justified 20");
    run_pcm(4'd5, 4, 170, "R4 right-justified 18");
    run_pcm(4'd6, 4, 210, "R9 code 6 ignored");
    run_pcm(4'd12, 4, 230, "R9 code 12 ignored");

    run_tdm('{256, 256, 256, 256, 256}, '{1, 32, 255, 2, 100}, 300, "R6 R7 TDM pulse widths");
    run_tdm('{256, 250, 256, 260, 256}, '{1, 10, 5, 200, 1}, 400, "R8 TDM bad frame length");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule